// File: doc/BRIEF.md
# Letterbox Force-Blank Timer

This block drives the display's force-blank control so that software gets a longer window for transfers into video memory. It raises force-blank on a programmable scanline near the bottom of the visible area, holds it through the frame wrap, and drops it on a second programmable scanline near the top. The visible picture becomes a letterbox, and the blanked lines lengthen the vertical blank. Every force-blank edge is taken at the rising edge of horizontal blank on the target line, never in the middle of a line. This avoids background tile corruption.

Software writes the two line settings at any time. They take effect only at the frame boundary, so one frame never mixes settings. The block also reports how many transfer bytes the blanked visible lines provide, at a fixed count per line.

A work-pending input tells the block that transfer work is still running. If that input is still high when the release line is reached, the block treats it as an overrun. It keeps the screen blanked for the rest of the frame and sets a sticky flag.

Top module: `letterbox_timer`

## Requirements
- R1: After reset, force_blank, xvb_active and overrun are 0. The active settings are "no bottom band" (start line 224) and "no top band" (release line 0), so budget is 0.
- R2: On the rising edge of hblank on the active start line, force_blank and xvb_active go to 1. This applies only when the start line is below 224.
- R3: Force-blank persists across the frame wrap. On the rising edge of hblank on the active release line, if work_pending is 0, force_blank and xvb_active both return to 0. xvb_active is never 1 while force_blank is 0.
- R4: force_blank changes only in the cycle after a rising edge of hblank. While hblank stays low on a target line, nothing changes.
- R5: cfg_start_line and cfg_release_line are copied into the active settings only at the rising edge of hblank on line 261. A write at any other time has no effect on behaviour or budget until then.
- R6: If the release value copied at the frame boundary is 0, the top band is off: force_blank and xvb_active go to 0 at that boundary. Otherwise both go to 1 there.
- R7: If work_pending is 1 on the rising edge of hblank on the release line, overrun goes to 1, xvb_active goes to 0, and force_blank stays 1 until the next frame boundary. Overrun stays 1 until reset.
- R8: budget = 165 × n, where n = min(release line, 224) + (224 − start line, when the start line is below 224). n is capped at 224 and computed from the active settings.
- R9: A start line of 224 or more never raises force_blank during the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line | input | 9 | Current scanline, 0..261 |
| hblank | input | 1 | High during horizontal blank |
| cfg_start_line | input | 9 | Requested first blanked line at the bottom |
| cfg_release_line | input | 9 | Requested line on which the display resumes; 0 disables the top band |
| work_pending | input | 1 | High while extended-blank transfer work is unfinished |
| force_blank | output | 1 | Force-blank control to the display |
| xvb_active | output | 1 | Extended-blank transfer window open |
| overrun | output | 1 | Sticky: work was still pending at the release line |
| budget | output | 16 | Transfer bytes provided by the blanked visible lines |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is the release and the overrun decision. Both are taken at one hblank edge on the release line. The bench releases once with work_pending low and once with it high. It judges by whether force_blank falls, or stays high with xvb_active cleared and overrun set.

The second pair is the frame-boundary latch and a configuration write. The bench changes the settings mid-frame. It then checks that neither budget nor blanking moves until the line-261 hblank edge, and that both pick up the new values right after it.

// File: rtl/lbx_pkg.sv
package lbx_pkg;

  // Number of visible lines removed by both bands, capped at the visible height.
  function automatic int unsigned blanked_lines(input int unsigned start_ln,
                                                input int unsigned release_ln,
                                                input int unsigned visible);
    int unsigned top_n;
    int unsigned bot_n;
    int unsigned sum_n;
    top_n = (release_ln < visible) ? release_ln : visible;
    bot_n = (start_ln < visible) ? (visible - start_ln) : 0;
    sum_n = top_n + bot_n;
    return (sum_n > visible) ? visible : sum_n;
  endfunction

endpackage

// File: rtl/lbx_events.sv
module lbx_events #(
  parameter int LINE_W  = 9,
  parameter int LINES   = 262,
  parameter int VISIBLE = 224
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line,
  input  logic              hblank,
  input  logic [LINE_W-1:0] act_start,
  input  logic [LINE_W-1:0] act_release,
  output logic              hb_rise,
  output logic              wrap_ev,
  output logic              start_ev,
  output logic              release_ev
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] VIS_LINES = LINE_W'(VISIBLE);

  logic hblank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hblank_q <= 1'b0;
    else        hblank_q <= hblank;
  end

  assign hb_rise    = hblank & ~hblank_q;
  assign wrap_ev    = hb_rise && (line == LAST_LINE);
  assign start_ev   = hb_rise && (act_start < VIS_LINES) && (line == act_start);
  assign release_ev = hb_rise && (act_release != '0) && (line == act_release);

  // events never fire outside a horizontal blank (R4)
  assert_event_in_hblank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev || start_ev || release_ev) |-> hblank);

endmodule

// File: rtl/lbx_cfg.sv
module lbx_cfg #(
  parameter int LINE_W  = 9,
  parameter int VISIBLE = 224
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_ev,
  input  logic [LINE_W-1:0] cfg_start_line,
  input  logic [LINE_W-1:0] cfg_release_line,
  output logic [LINE_W-1:0] act_start,
  output logic [LINE_W-1:0] act_release
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_start   <= LINE_W'(VISIBLE);
      act_release <= '0;
    end else if (wrap_ev) begin
      act_start   <= cfg_start_line;
      act_release <= cfg_release_line;
    end
  end

  // settings move only at the frame boundary (R5)
  assert_cfg_frame_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_ev |=> ($stable(act_start) && $stable(act_release)));

endmodule

// File: rtl/lbx_band.sv
module lbx_band (
  input  logic clk,
  input  logic rst_n,
  input  logic hblank,
  input  logic wrap_ev,
  input  logic top_band_on,
  input  logic start_ev,
  input  logic release_ev,
  input  logic work_pending,
  output logic force_blank,
  output logic xvb_active,
  output logic overrun
);
  logic release_ok;
  logic overrun_hit;

  // release only counts while the window is still open
  assign release_ok  = release_ev && xvb_active && !work_pending;
  assign overrun_hit = release_ev && xvb_active &&  work_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_blank <= 1'b0;
      xvb_active  <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      if (wrap_ev) begin
        force_blank <= top_band_on;
        xvb_active  <= top_band_on;
      end else if (start_ev) begin
        force_blank <= 1'b1;
        xvb_active  <= 1'b1;
      end else if (release_ok) begin
        force_blank <= 1'b0;
        xvb_active  <= 1'b0;
      end else if (overrun_hit) begin
        xvb_active  <= 1'b0;
      end
      if (overrun_hit) overrun <= 1'b1;
    end
  end

  assert_blank_edge_in_hblank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (force_blank != $past(force_blank)) |-> $past(hblank));

  assert_window_inside_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xvb_active |-> force_blank);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_overrun_keeps_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_hit |=> (force_blank && !xvb_active));

endmodule

// File: rtl/letterbox_timer.sv
module letterbox_timer #(
  parameter int LINE_W         = 9,
  parameter int LINES          = 262,
  parameter int VISIBLE        = 224,
  parameter int BYTES_PER_LINE = 165,
  parameter int BUDGET_W       = $clog2(BYTES_PER_LINE * VISIBLE + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINE_W-1:0]   line,
  input  logic                hblank,
  input  logic [LINE_W-1:0]   cfg_start_line,
  input  logic [LINE_W-1:0]   cfg_release_line,
  input  logic                work_pending,
  output logic                force_blank,
  output logic                xvb_active,
  output logic                overrun,
  output logic [BUDGET_W-1:0] budget
);
  import lbx_pkg::*;

  localparam int MAX_BUDGET = BYTES_PER_LINE * VISIBLE;

  logic [LINE_W-1:0] act_start;
  logic [LINE_W-1:0] act_release;
  logic              hb_rise;
  logic              wrap_ev;
  logic              start_ev;
  logic              release_ev;
  logic              top_band_on;

  lbx_events #(.LINE_W(LINE_W), .LINES(LINES), .VISIBLE(VISIBLE)) u_events (
    .clk(clk), .rst_n(rst_n), .line(line), .hblank(hblank),
    .act_start(act_start), .act_release(act_release),
    .hb_rise(hb_rise), .wrap_ev(wrap_ev), .start_ev(start_ev), .release_ev(release_ev)
  );

  lbx_cfg #(.LINE_W(LINE_W), .VISIBLE(VISIBLE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wrap_ev(wrap_ev),
    .cfg_start_line(cfg_start_line), .cfg_release_line(cfg_release_line),
    .act_start(act_start), .act_release(act_release)
  );

  assign top_band_on = (cfg_release_line != '0);

  lbx_band u_band (
    .clk(clk), .rst_n(rst_n), .hblank(hblank),
    .wrap_ev(wrap_ev), .top_band_on(top_band_on),
    .start_ev(start_ev), .release_ev(release_ev), .work_pending(work_pending),
    .force_blank(force_blank), .xvb_active(xvb_active), .overrun(overrun)
  );

  assign budget = BUDGET_W'(blanked_lines(int'(act_start), int'(act_release), VISIBLE)
                            * BYTES_PER_LINE);

  assert_budget_capped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(budget) <= MAX_BUDGET);

  assert_start_needs_hblank_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xvb_active) |-> $past(hb_rise));

endmodule

// File: tb/sim_letterbox_timer.sv
module sim_letterbox_timer;
  localparam int CLK_PERIOD = 10;
  localparam int VIS = 224;
  localparam int BPL = 165;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  line = '0;
  logic        hblank = 1'b0;
  logic [8:0]  cfg_start_line = 9'd224;
  logic [8:0]  cfg_release_line = '0;
  logic        work_pending = 1'b0;
  logic        force_blank;
  logic        xvb_active;
  logic        overrun;
  logic [15:0] budget;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  letterbox_timer u0 (
    .clk(clk), .rst_n(rst_n), .line(line), .hblank(hblank),
    .cfg_start_line(cfg_start_line), .cfg_release_line(cfg_release_line),
    .work_pending(work_pending), .force_blank(force_blank),
    .xvb_active(xvb_active), .overrun(overrun), .budget(budget)
  );

  function automatic int exp_budget(input int s, input int r);
    int t;
    int b;
    t = (r < VIS) ? r : VIS;
    b = (s < VIS) ? VIS - s : 0;
    return ((t + b > VIS) ? VIS : t + b) * BPL;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input int fb, input int xv, input int ov);
    check(req, "force_blank", int'(force_blank), fb);
    check(req, "xvb_active", int'(xvb_active), xv);
    check(req, "overrun", int'(overrun), ov);
  endtask

  // drive a line with hblank low only; outputs are sampled at the end
  task automatic line_no_hblank(input int l);
    @(negedge clk);
    line = 9'(l);
    hblank = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // drive a whole line: active part, then a two-cycle hblank, then sample
  task automatic run_line(input int l, input bit wp);
    @(negedge clk);
    line = 9'(l);
    hblank = 1'b0;
    work_pending = wp;
    repeat (2) @(negedge clk);
    hblank = 1'b1;
    repeat (2) @(negedge clk);
    hblank = 1'b0;
    work_pending = 1'b0;
  endtask

  task automatic t_reset;
    check_out("R1", 0, 0, 0);
    check("R1", "budget", int'(budget), 0);
  endtask

  task automatic t_latch_and_top_band;
    cfg_start_line = 9'd200;
    cfg_release_line = 9'd16;
    run_line(100, 0);
    check_out("R5", 0, 0, 0);
    check("R5", "budget before boundary", int'(budget), 0);
    run_line(200, 0);
    check_out("R9", 0, 0, 0);
    run_line(261, 0);
    check_out("R6", 1, 1, 0);
    check("R8", "budget 200/16", int'(budget), exp_budget(200, 16));
  endtask

  task automatic t_release_and_start;
    run_line(5, 0);
    check_out("R3", 1, 1, 0);
    line_no_hblank(16);
    check_out("R4", 1, 1, 0);
    run_line(16, 0);
    check_out("R3", 0, 0, 0);
    run_line(199, 0);
    check_out("R2", 0, 0, 0);
    line_no_hblank(200);
    check_out("R4", 0, 0, 0);
    run_line(200, 0);
    check_out("R2", 1, 1, 0);
    run_line(261, 0);
    check_out("R3", 1, 1, 0);
  endtask

  task automatic t_overrun;
    run_line(16, 1);
    check_out("R7", 1, 0, 1);
    cfg_start_line = 9'd216;
    cfg_release_line = 9'd0;
    run_line(100, 0);
    check_out("R7", 1, 0, 1);
    check("R5", "budget after mid-frame write", int'(budget), exp_budget(200, 16));
    run_line(261, 0);
    check_out("R6", 0, 0, 1);
    check("R8", "budget 216/0", int'(budget), exp_budget(216, 0));
  endtask

  task automatic t_no_top_band_and_cap;
    run_line(0, 0);
    check_out("R6", 0, 0, 1);
    run_line(216, 0);
    check_out("R2", 1, 1, 1);
    cfg_start_line = 9'd100;
    cfg_release_line = 9'd200;
    run_line(261, 0);
    check_out("R6", 1, 1, 1);
    check("R8", "budget capped", int'(budget), exp_budget(100, 200));
    run_line(200, 0);
    check_out("R3", 0, 0, 1);
    cfg_start_line = 9'd230;
    cfg_release_line = 9'd0;
    run_line(261, 0);
    check("R8", "budget none", int'(budget), 0);
    run_line(230, 0);
    check_out("R9", 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_and_top_band();
    t_release_and_start();
    t_overrun();
    t_no_top_band_and_cap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule